// File: doc/BRIEF.md
# Seconds Watchdog Timer with Reset/Power-Off Action

This block is a watchdog timer that counts down in whole seconds and sits behind a small register window of two 32-bit words. Software programs a timeout between 1 and 1023 seconds and sets a run bit. It then keeps writing a trigger bit, and each trigger restarts the countdown from the programmed value. If software stops triggering, the count reaches zero while the timer runs. The block then pulses one request line towards the system reset controller. A control bit decides whether that line is the system-reset request or the power-off request.

A prescaler divides the core clock into a one-cycle tick per second, and the divider ratio is a parameter. The block has two reset inputs. The power-on reset clears everything. The system reset is the reset the watchdog may itself have caused, and it clears everything except a sticky fired flag. Software reads that flag after reboot to learn that the watchdog caused the restart.

Two static enable inputs gate the block. One enables the watchdog function and the other enables the register window. The registers answer only when both are high.

Top module: `wdog_timer`

## Requirements
- R1: A register access takes effect only when `funcEn`, `winEn` and `busSel` are all high and `busAddr[1:0]` is 0. Otherwise a read returns 0 and a write changes nothing.
- R2: The control word at offset 0 has the following fields:
  - bit 0: run, read/write.
  - bit 1: fired flag.
  - bit 2: action select, 0 = reset request, 1 = power-off request.
  - bit 3: reads as the inverse of run.
  - bit 7: trigger, always reads 0.
  - All other bits read 0.
- R3: The timeout word at offset 4 holds the programmed timeout in bits [9:0], and a write of 0 to that field is ignored. Bits [25:16] read the remaining count, and all other bits read 0.
- R4: Writing 1 to control bit 7 loads the remaining count from the timeout and restarts the one-second prescaler. While run is 0 the count is loaded but does not decrement.
- R5: While run and `funcEn` are both high, the count decrements once every `TICK_DIV` cycles. After a trigger write with timeout T, the request appears exactly T*`TICK_DIV` cycles after that write's clock edge.
- R6: Clearing run freezes the count, and no request is ever issued while run is 0.
- R7: On expiry exactly one of `rstReq` and `pwrOffReq` is high, for exactly `PULSE_LEN` cycles. Control bit 2 selects which one. Expiry also clears run.
- R8: The fired flag is set on expiry and is kept through `sysRstN`. Only `porRstN` or a write of 1 to control bit 1 clears it.
- R9: While `funcEn` is low the countdown is frozen and no expiry can occur.
- R10: After either reset, run is 0, action select is 0, and both the timeout and the remaining count equal `DEF_TIMEOUT`.
- R11: A trigger written before expiry keeps the timer from ever issuing a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| porRstN | input | 1 | Power-on reset, active low, clears everything |
| sysRstN | input | 1 | System reset, active low, keeps the fired flag |
| funcEn | input | 1 | Watchdog function enable |
| winEn | input | 1 | Register window enable |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Byte offset into the 8-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, 0 when no valid read |
| rstReq | output | 1 | System-reset request pulse |
| pwrOffReq | output | 1 | Power-off request pulse |

## Verification
The assertions check the following on every cycle:
- The two request lines are never high together.
- The count stays frozen while the timer is stopped and no trigger is written.
- A request starts only when the count has reached zero, and the fired flag is already set at that point.
- Every request pulse lasts exactly `PULSE_LEN` cycles.
- The trigger bit never reads back as 1.

Only the bench scenarios can show the following:
- The exact expiry cycle relative to a trigger write.
- Which line the action-select bit picks.
- That the fired flag survives a system reset but not a power-on reset.
- That keepalive triggers, a frozen `funcEn` and a closed register window all hold the timer off.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 10;

  typedef struct packed {
    logic             reload;   // trigger: restart countdown
    logic             countEn;  // prescaler and countdown may advance
    logic [CNT_W-1:0] timeout;  // value to load on reload
  } wdogStb_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter logic [CNT_W-1:0] DEF_TIMEOUT = 10'd60
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             funcEn,
  input  logic             winEn,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [2:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             expire,
  input  logic [CNT_W-1:0] remain,
  output wdogStb_t         stb,
  output logic             runBit,
  output logic             firedBit,
  output logic             pwrSel
);
  logic             accOk;
  logic             wrCtl;
  logic             wrTo;
  logic             rdOk;
  logic [CNT_W-1:0] timeoutReg;
  logic [21:0]      wdataUnused;

  assign wdataUnused = busWdata[31:10];

  assign accOk = funcEn & winEn & busSel & (busAddr[1:0] == 2'b00);
  assign wrCtl = accOk & busWrite & ~busAddr[2];
  assign wrTo  = accOk & busWrite & busAddr[2];
  assign rdOk  = accOk & ~busWrite;

  // run bit and action select live in the system-reset domain
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      runBit     <= 1'b0;
      pwrSel     <= 1'b0;
      timeoutReg <= DEF_TIMEOUT;
    end else begin
      if (expire)     runBit <= 1'b0;
      else if (wrCtl) runBit <= busWdata[0];
      if (wrCtl)      pwrSel <= busWdata[2];
      if (wrTo && (busWdata[CNT_W-1:0] != '0)) timeoutReg <= busWdata[CNT_W-1:0];
    end
  end

  // fired flag only cleared by power-on reset or software
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                   firedBit <= 1'b0;
    else if (expire)                firedBit <= 1'b1;
    else if (wrCtl && busWdata[1])  firedBit <= 1'b0;
  end

  always_comb begin
    stb.reload  = wrCtl & busWdata[7];
    stb.countEn = runBit & funcEn;
    stb.timeout = timeoutReg;
  end

  always_comb begin
    busRdata = '0;
    if (rdOk) begin
      if (busAddr[2]) begin
        busRdata[CNT_W-1:0]   = timeoutReg;
        busRdata[16+:CNT_W]   = remain;
      end else begin
        busRdata[0] = runBit;
        busRdata[1] = firedBit;
        busRdata[2] = pwrSel;
        busRdata[3] = ~runBit;
      end
    end
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned      TICK_DIV    = 200_000_000,
  parameter logic [CNT_W-1:0] DEF_TIMEOUT = 10'd60
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  wdogStb_t         stb,
  output logic [CNT_W-1:0] remain,
  output logic             expire
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;

  assign tick   = stb.countEn & ~stb.reload & (preCnt == PRE_LAST);
  assign expire = tick & (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                preCnt <= '0;
    else if (stb.reload)         preCnt <= '0;
    else if (stb.countEn)        preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)                       remain <= DEF_TIMEOUT;
    else if (stb.reload)                remain <= stb.timeout;
    else if (tick && (remain != '0))    remain <= remain - 1'b1;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic porRstN,
  input  logic expire,
  input  logic pwrSel,
  output logic rstReq,
  output logic pwrOffReq
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulseCnt;
  logic          selLatch;

  // power-on domain so the pulse outlives the reset it causes
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pulseCnt <= '0;
      selLatch <= 1'b0;
    end else if (expire) begin
      pulseCnt <= PW'(PULSE_LEN);
      selLatch <= pwrSel;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign rstReq    = (pulseCnt != '0) & ~selLatch;
  assign pwrOffReq = (pulseCnt != '0) &  selLatch;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned      TICK_DIV    = 200_000_000,
  parameter int unsigned      PULSE_LEN   = 16,
  parameter logic [CNT_W-1:0] DEF_TIMEOUT = 10'd60
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  logic        funcEn,
  input  logic        winEn,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        rstReq,
  output logic        pwrOffReq
);
  wdogStb_t         stb;
  logic             expire;
  logic [CNT_W-1:0] remain;
  logic             runBit;
  logic             firedBit;
  logic             pwrSel;

  wdog_ctrl #(.DEF_TIMEOUT(DEF_TIMEOUT)) u_ctrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .funcEn(funcEn), .winEn(winEn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .expire(expire), .remain(remain), .stb(stb),
    .runBit(runBit), .firedBit(firedBit), .pwrSel(pwrSel)
  );

  wdog_datapath #(.TICK_DIV(TICK_DIV), .DEF_TIMEOUT(DEF_TIMEOUT)) u_dp (
    .clk(clk), .sysRstN(sysRstN), .stb(stb), .remain(remain), .expire(expire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .porRstN(porRstN), .expire(expire), .pwrSel(pwrSel),
    .rstReq(rstReq), .pwrOffReq(pwrOffReq)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned PULSE_LEN = 16
) (
  input logic        clk,
  input logic        porRstN,
  input logic        sysRstN,
  input logic        rstReq,
  input logic        pwrOffReq,
  input logic [31:0] busRdata,
  input logic        runBit,
  input logic        firedBit,
  input logic        reload,
  input logic [9:0]  remain
);
  localparam int HW = $clog2(PULSE_LEN + 2) + 1;
  logic          anyReq;
  logic [HW-1:0] highCnt;

  assign anyReq = rstReq | pwrOffReq;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)    highCnt <= '0;
    else if (anyReq) highCnt <= (highCnt == '1) ? highCnt : highCnt + 1'b1;
    else             highCnt <= '0;
  end

  p_one_req_r7: assert property (@(posedge clk) disable iff (!porRstN)
    !(rstReq && pwrOffReq));

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(anyReq) |-> (highCnt == HW'(PULSE_LEN)));

  p_halt_freeze_r6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (!runBit && !reload) |=> $stable(remain));

  p_req_at_zero_r5: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    $rose(anyReq) |-> (remain == 10'd0));

  p_fired_set_r8: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(anyReq) |-> firedBit);

  p_trig_zero_r2: assert property (@(posedge clk) disable iff (!porRstN)
    busRdata[7] == 1'b0);
endmodule

bind wdog_timer wdog_timer_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
  .rstReq(rstReq), .pwrOffReq(pwrOffReq), .busRdata(busRdata),
  .runBit(runBit), .firedBit(firedBit), .reload(stb.reload), .remain(remain)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam int DIV  = 8;
  localparam int PLEN = 4;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0, sysRstN = 1'b0;
  logic        funcEn = 1'b1, winEn = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq, pwrOffReq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.TICK_DIV(DIV), .PULSE_LEN(PLEN), .DEF_TIMEOUT(10'd60)) u_wdog_timer (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .funcEn(funcEn), .winEn(winEn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rstReq(rstReq), .pwrOffReq(pwrOffReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0; busWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #0.5 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic anyReqSeen(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstReq || pwrOffReq) seen = 1;
    end
  endtask

  // expiry check: trigger write already done; we sit at negedge after its edge
  task automatic expectExpiry(input string req, input int t, input bit pwr);
    int w = 0;
    bit early = 0;
    for (int i = 0; i < t*DIV - 1; i++) begin
      @(negedge clk);
      if (rstReq || pwrOffReq) early = 1;
    end
    check({req, " no early request"}, early, 0);
    @(negedge clk);
    check({req, " reset line at expiry"}, rstReq, !pwr);
    check({req, " power-off line at expiry"}, pwrOffReq, pwr);
    while ((rstReq || pwrOffReq) && w < 100) begin
      w++;
      @(negedge clk);
    end
    check({req, " pulse width"}, w, PLEN);
  endtask

  task automatic porReset();
    @(negedge clk);
    porRstN = 0; sysRstN = 0;
    idle(2);
    porRstN = 1; sysRstN = 1;
    idle(1);
  endtask

  task automatic t_window_gate();
    logic [31:0] d;
    winEn = 0;
    wr(3'd4, 32'd5);
    rd(3'd0, d); check("R1 read while window closed", d, 0);
    winEn = 1;
    rd(3'd4, d); check("R1 write ignored when closed / R10 reset", d, {6'd0, 10'd60, 6'd0, 10'd60});
    rd(3'd0, d); check("R2 R10 control reset value", d, 32'h08);
    rd(3'd1, d); check("R1 misaligned read", d, 0);
  endtask

  task automatic t_timeout_reg();
    logic [31:0] d;
    wr(3'd4, 32'd0);
    rd(3'd4, d); check("R3 zero timeout ignored", d[9:0], 10'd60);
    wr(3'd4, 32'hFFFF_F003);
    rd(3'd4, d); check("R3 timeout written", d[9:0], 10'd3);
    check("R3 unused bits zero", {d[31:26], d[15:10]}, 0);
  endtask

  task automatic t_trig_stopped();
    logic [31:0] d;
    wr(3'd0, 32'h80);
    idle(5*DIV);
    rd(3'd4, d); check("R4 reload while stopped", d[25:16], 10'd3);
    rd(3'd0, d); check("R2 R4 trigger reads 0, still stopped", d, 32'h08);
  endtask

  task automatic t_expire_reset();
    logic [31:0] d;
    wr(3'd0, 32'h81);
    expectExpiry("R5 R7 reset action", 3, 0);
    rd(3'd0, d); check("R7 R8 run cleared, fired set", d, 32'h0A);
  endtask

  task automatic t_fired_sticky();
    logic [31:0] d;
    @(negedge clk); sysRstN = 0; idle(2); sysRstN = 1; idle(1);
    rd(3'd0, d); check("R8 fired kept through system reset", d, 32'h0A);
    rd(3'd4, d); check("R10 timeout after system reset", d[9:0], 10'd60);
    wr(3'd0, 32'h02);
    rd(3'd0, d); check("R8 fired cleared by write", d, 32'h08);
  endtask

  task automatic t_expire_pwroff();
    logic [31:0] d;
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h85);
    expectExpiry("R7 power-off action", 2, 1);
    rd(3'd0, d); check("R2 R7 action bit kept", d, 32'h0E);
    porReset();
    winEn = 1;
    rd(3'd0, d); check("R8 fired cleared by power-on reset", d, 32'h08);
  endtask

  task automatic t_halt();
    logic [31:0] d;
    bit seen;
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h81);
    idle(DIV);
    wr(3'd0, 32'h00);
    rd(3'd4, d);
    anyReqSeen(6*DIV, seen);
    check("R6 no request after halt", seen, 0);
    check("R6 count frozen after halt", d[25:16], 10'd1);
    rd(3'd4, d); check("R6 count still frozen", d[25:16], 10'd1);
  endtask

  task automatic t_func_freeze();
    logic [31:0] d;
    bit seen;
    wr(3'd4, 32'd4);
    wr(3'd0, 32'h81);
    idle(2);
    funcEn = 0;
    anyReqSeen(20*DIV, seen);
    funcEn = 1;
    rd(3'd4, d);
    check("R9 no request while function disabled", seen, 0);
    check("R9 count frozen while function disabled", d[25:16], 10'd4);
    wr(3'd0, 32'h00);
  endtask

  task automatic t_keepalive();
    bit seen, any = 0;
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h81);
    for (int i = 0; i < 8; i++) begin
      anyReqSeen(DIV + 3, seen);
      if (seen) any = 1;
      wr(3'd0, 32'h81);
    end
    check("R11 keepalive prevents expiry", any, 0);
    wr(3'd0, 32'h00);
  endtask

  initial begin
    idle(3);
    porRstN = 1; sysRstN = 1;
    idle(2);
    t_window_gate();
    t_timeout_reg();
    t_trig_stopped();
    t_expire_reset();
    t_fired_sticky();
    t_expire_pwroff();
    t_halt();
    t_func_freeze();
    t_keepalive();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule